// File: doc/BRIEF.md
# Memory Slave with Programmable Wait States

This block is a pipelined bus memory slave built around a small word-organised RAM. For every transfer it accepts, it stretches the data phase by a configurable number of wait cycles, W. It signals each wait cycle by holding its ready output low. No data moves in a wait cycle. After the W wait cycles it raises ready for exactly one cycle, and the beat completes in that cycle.

The slave handles single transfers and incrementing bursts. Each beat of a burst is a separate transfer with its own full set of W waits, so a burst takes the same number of wait cycles per beat as the same beats issued one by one. Idle and busy slots never create a data phase, and the slave answers them with zero waits.

The block is useful as a controlled slow target when measuring how bus throughput falls as W grows. With W=0 it completes one beat per cycle. Each extra wait cycle per beat adds one cycle to every beat.

Top module: `wsm_slave`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `hreadyout` is 1, `hresp` is 0 and `hrdata` is 0.
- R2: Every accepted transfer has a data phase of exactly 1+W cycles. In the first W cycles `hreadyout` is 0, and in the last cycle `hreadyout` is 1.
- R3: Every beat of an incrementing burst pays the full W waits. An N-beat burst at a fixed W therefore spans N*(1+W) data-phase cycles after its single first address cycle. For example, 16 beats with W=2 span 48 cycles.
- R4: When W=0, `hreadyout` stays 1 through a burst, and the slave completes one beat in every cycle back to back.
- R5: W is taken from `wait_cfg` in the cycle in which the transfer's address is accepted. A change to `wait_cfg` during a data phase affects only transfers accepted later.
- R6: A slot with `htrans` IDLE (2'b00) or BUSY (2'b01) starts no data phase, and `hreadyout` is 1 in the following cycle.
- R7: Address and control are accepted only at a clock edge where `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). A transfer presented while `hready` is 0 is neither captured nor carried out.
- R8: A write is committed to RAM only at the end of the completing cycle. The byte lanes written follow `hsize`, where 0 is a byte, 1 a halfword and 2 a word. The lanes also follow the low address bits, with lane k holding bits 8k+7:8k, so a byte write to offset k changes lane k only and a halfword write changes lanes `haddr[1]`*2 and `haddr[1]`*2+1. The word index is `haddr[7:2]`.
- R9: A read returns the whole addressed word on `hrdata` only in the completing cycle. In every other cycle `hrdata` is 0.
- R10: `hresp` is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| haddr | input | ADDR_W (8) | Byte address of the address phase |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| hwdata | input | DATA_W (32) | Write data during the data phase |
| hready | input | 1 | Bus-wide ready; a transfer completes and the next address is taken when it is 1 |
| wait_cfg | input | WAIT_W (4) | Number of wait cycles W for transfers accepted now |
| hrdata | output | DATA_W (32) | Read data, valid in the completing cycle only |
| hreadyout | output | 1 | Slave ready; 0 during wait cycles |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
The bench counts the cycles of every data phase against 1+W. It also compares the total length of long bursts, so a design that waits only on the first beat of a burst comes up short by (N-1)*W cycles. A second burst changes `wait_cfg` in the middle of the first beat. A slave that reads W live during the data phase would then end that beat early, while one that never picks up the new value would keep the later beats long. Other directed cases cover the following. A NONSEQ write is presented while an outside stall holds `hready` low, and a slave that captures it would stall or corrupt the RAM. Byte and halfword writes land on each lane offset, and a wrong lane decode shows up when the word is read back. `hrdata` is watched through every wait cycle for data that leaks early.

// File: rtl/wsm_pkg.sv
// Package: transfer type encoding shared by the wait-state memory slave.
// Assumes the standard two-bit transfer encoding of the pipelined bus.
package wsm_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;
endpackage

// File: rtl/wsm_wait_ctrl.sv
// Wait counter: loads the configured wait count when a transfer is accepted and
// counts it down; the slave is ready whenever the count is zero.
// Assumes start only pulses at an edge where the bus-wide ready is high.
module wsm_wait_ctrl #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              ready_o
);
    logic [WAIT_W-1:0] cnt;

    // Load W on acceptance, otherwise count the remaining waits down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= wait_cfg;
        end else if (cnt != '0) begin
            cnt <= cnt - WAIT_W'(1);
        end
    end

    // Ready is high exactly when no wait cycles remain.
    always_comb ready_o = (cnt == '0);

    AST_WAIT_INSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wait_cfg != '0) |=> !ready_o);            // R2
    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wait_cfg == '0) |=> ready_o);             // R4
endmodule

// File: rtl/wsm_addr_phase.sv
// Address-phase register: captures address and control of a NONSEQ or SEQ
// transfer at an edge where the bus-wide ready is high, and marks the data
// phase that follows. Assumes the master holds its address while ready is low.
module wsm_addr_phase
    import wsm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    output logic              accept,
    output logic              dp_active,
    output logic [ADDR_W-1:0] dp_addr,
    output logic              dp_write,
    output logic [2:0]        dp_size
);
    // A transfer is taken only for an active transfer type with ready high.
    always_comb accept = hready &&
        ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));

    // Advance the data-phase register on every ready edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_active <= 1'b0;
            dp_addr   <= '0;
            dp_write  <= 1'b0;
            dp_size   <= '0;
        end else if (hready) begin
            dp_active <= accept;
            if (accept) begin
                dp_addr  <= haddr;
                dp_write <= hwrite;
                dp_size  <= hsize;
            end
        end
    end

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(dp_addr) && $stable(dp_write)));   // R7
endmodule

// File: rtl/wsm_ram.sv
// Word RAM with byte-lane writes: lanes are chosen from transfer size and the
// low address bits; reads are asynchronous on the word index.
// Assumes the address is naturally aligned to the transfer size.
module wsm_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(DEPTH)-1:0]   idx,
    input  logic [$clog2(DATA_W/8)-1:0] lo,
    input  logic [2:0]                 size,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [BYTES-1:0]  lane_en;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        // A lane is written when it falls in the same size-aligned block as the address.
        always_comb lane_en[b] = ((LANE_W'(b) >> size) == (lo >> size));

        // Commit this byte lane on a write.
        always_ff @(posedge clk) begin
            if (we && lane_en[b]) begin
                mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    // Read the whole addressed word.
    always_comb rdata = mem[idx];
endmodule

// File: rtl/wsm_slave.sv
// Memory slave with programmable wait states: every accepted transfer gets W
// wait cycles with ready low, then one completing cycle in which write data is
// committed or read data is driven. Response is always OKAY.
// Assumes a single-slave or muxed system where hready follows the selected slave.
module wsm_slave
    import wsm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int WAIT_W = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LANE_W = $clog2(DATA_W/8);

    logic              accept;
    logic              dp_active;
    logic [ADDR_W-1:0] dp_addr;
    logic              dp_write;
    logic [2:0]        dp_size;
    logic              wc_ready;
    logic              complete;
    logic [DATA_W-1:0] ram_rdata;

    wsm_addr_phase #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .hready(hready), .htrans(htrans),
        .haddr(haddr), .hwrite(hwrite), .hsize(hsize), .accept(accept),
        .dp_active(dp_active), .dp_addr(dp_addr), .dp_write(dp_write),
        .dp_size(dp_size)
    );

    wsm_wait_ctrl #(.WAIT_W(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .start(accept), .wait_cfg(wait_cfg),
        .ready_o(wc_ready)
    );

    // The beat completes when waits are spent and the bus is ready.
    always_comb complete = dp_active && wc_ready && hready;

    wsm_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(complete && dp_write),
        .idx(dp_addr[IDX_W+LANE_W-1:LANE_W]), .lo(dp_addr[LANE_W-1:0]),
        .size(dp_size), .wdata(hwdata), .rdata(ram_rdata)
    );

    // Drive bus outputs: data only in the completing read cycle, OKAY always.
    always_comb begin
        hreadyout = wc_ready;
        hresp     = 1'b0;
        hrdata    = (complete && !dp_write) ? ram_rdata : '0;
    end

    AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (htrans == TR_IDLE || htrans == TR_BUSY)) |=> hreadyout);  // R6
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> (hrdata == '0));                                    // R9
    AST_WAIT_STALLS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active && !hreadyout) |=> dp_active);                          // R2
endmodule

// File: tb/wsm_slave_bench.sv
// Bench: directed corner cases plus seeded random bursts; counts the cycles of
// every data phase and checks data against a bench memory model.
module wsm_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic        ext_stall = 1'b0;
    logic [3:0]  wait_cfg = '0;
    logic        hready;
    logic [31:0] hrdata;
    logic        hreadyout;
    logic        hresp;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [64];

    always #2.5 clk = ~clk;
    assign hready = hreadyout & ~ext_stall;

    wsm_slave u_wsm_slave (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
        .wait_cfg(wait_cfg), .hrdata(hrdata), .hreadyout(hreadyout),
        .hresp(hresp)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Merge write data into a model word by size and byte offset (R8).
    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                          input logic [2:0] sz, input logic [1:0] off);
        logic [31:0] res = old;
        int nb = (sz >= 3'd2) ? 4 : (1 << sz);
        int first = (int'(off) / nb) * nb;
        for (int k = first; k < first + nb; k++) res[8*k +: 8] = wd[8*k +: 8];
        return res;
    endfunction

    // One transfer sequence: n beats from addr, W=w; if chg, wait_cfg moves to
    // chgv during the first data phase so later beats must use chgv (R5).
    task automatic run(input logic [7:0] addr, input int n, input bit wr,
                       input logic [2:0] sz, input int w, input bit chg, input int chgv);
        int total = 0;
        int exp_total = 0;
        int step = 1 << sz;
        logic [7:0] a = addr;
        @(negedge clk);
        wait_cfg = 4'(w);
        haddr = a; htrans = 2'b10; hwrite = wr; hsize = sz;
        for (int i = 0; i < n; i++) begin
            logic [7:0]  cur = a;
            logic [31:0] wd = $urandom;
            int cyc = 1;
            bit quiet = 1'b1;
            int expw = (chg && i > 0) ? chgv : w;
            @(negedge clk);
            if (chg && i == 0) wait_cfg = 4'(chgv);
            hwdata = wd;
            if (i + 1 < n) begin
                a = a + 8'(step);
                haddr = a; htrans = 2'b11;
            end else begin
                htrans = 2'b00;
            end
            while (!hreadyout) begin
                if (hrdata != '0) quiet = 1'b0;
                @(negedge clk);
                cyc++;
            end
            total += cyc;
            exp_total += expw + 1;
            if (chg) chk(cyc == expw + 1, "R5 W sampled at acceptance", 32'(cyc), 32'(expw + 1));
            else chk(cyc == expw + 1, "R2 data phase length 1+W", 32'(cyc), 32'(expw + 1));
            chk(quiet, "R9 hrdata zero during waits", {31'd0, quiet}, 32'd1);
            chk(hresp == 1'b0, "R10 response OKAY", {31'd0, hresp}, 32'd0);
            if (wr) model[cur[7:2]] = merge(model[cur[7:2]], wd, sz, cur[1:0]);
            else chk(hrdata == model[cur[7:2]], "R9 read data in completing cycle",
                     hrdata, model[cur[7:2]]);
        end
        if (n > 1) chk(total == exp_total, "R3 burst waits on every beat",
                       32'(total), 32'(exp_total));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(hreadyout == 1'b1, "R1 hreadyout in reset", {31'd0, hreadyout}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hreadyout == 1'b1, "R1 hreadyout after reset", {31'd0, hreadyout}, 32'd1);
        chk(hresp == 1'b0, "R1 hresp after reset", {31'd0, hresp}, 32'd0);
        chk(hrdata == '0, "R1 hrdata after reset", hrdata, 32'd0);

        // R4: fill the whole RAM with a zero-wait 64-beat burst, then read it back.
        for (int k = 0; k < 64; k++) model[k] = '0;
        run(8'h00, 64, 1'b1, 3'd2, 0, 1'b0, 0);
        run(8'h00, 64, 1'b0, 3'd2, 0, 1'b0, 0);

        // R3: 16 beats with W=2 each pay 2 waits.
        run(8'h40, 16, 1'b1, 3'd2, 2, 1'b0, 0);
        run(8'h40, 16, 1'b0, 3'd2, 2, 1'b0, 0);

        // R5: change W during a data phase, both directions.
        run(8'h10, 3, 1'b1, 3'd2, 3, 1'b1, 0);
        run(8'h10, 3, 1'b0, 3'd2, 0, 1'b1, 5);
        run(8'h20, 2, 1'b0, 3'd2, 15, 1'b1, 1);

        // R6: IDLE and BUSY slots see no waits even with a large W.
        @(negedge clk);
        wait_cfg = 4'd7; htrans = 2'b01;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(hreadyout == 1'b1, "R6 BUSY gets zero wait", {31'd0, hreadyout}, 32'd1);
        end
        htrans = 2'b00;
        @(negedge clk);
        chk(hreadyout == 1'b1, "R6 IDLE gets zero wait", {31'd0, hreadyout}, 32'd1);

        // R7: NONSEQ write presented while hready is held low must be ignored.
        @(negedge clk);
        ext_stall = 1'b1; wait_cfg = 4'd3;
        haddr = 8'h84; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2;
        @(negedge clk);
        htrans = 2'b00; ext_stall = 1'b0; hwdata = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(hreadyout == 1'b1, "R7 no data phase from stalled slot", {31'd0, hreadyout}, 32'd1);
        run(8'h84, 1, 1'b0, 3'd2, 1, 1'b0, 0);

        // R8: byte and halfword writes at every offset, then read back.
        for (int k = 0; k < 4; k++) run(8'(8'hA0 + k), 1, 1'b1, 3'd0, k, 1'b0, 0);
        run(8'hA0, 1, 1'b0, 3'd2, 0, 1'b0, 0);
        run(8'hB0, 1, 1'b1, 3'd1, 2, 1'b0, 0);
        run(8'hB2, 1, 1'b1, 3'd1, 0, 1'b0, 0);
        run(8'hB2, 1, 1'b1, 3'd0, 1, 1'b0, 0);
        run(8'hB0, 1, 1'b0, 3'd2, 4, 1'b0, 0);

        // Random mix with a fixed seed.
        void'($urandom(32'h5EED_0042));
        for (int t = 0; t < 60; t++) begin
            int n = 1 + int'($urandom % 8);
            int w = int'($urandom % 6);
            bit wr = 1'(($urandom % 2));
            logic [7:0] a;
            logic [2:0] sz;
            if (t % 3 == 0) begin
                sz = 3'($urandom % 3);
                a = 8'($urandom) & ~8'((1 << sz) - 1);
                run(a, 1, wr, sz, w, 1'b0, 0);
                run({a[7:2], 2'b00}, 1, 1'b0, 3'd2, w, 1'b0, 0);
            end else begin
                a = {6'($urandom), 2'b00};
                run(a, n, wr, 3'd2, w, (t % 7 == 0), int'($urandom % 4));
            end
        end
        @(negedge clk);
        summary();
    end
endmodule